// File: doc/BRIEF.md
# Single-wire slave bit engine

This block is the link layer on the slave side of a single-wire open-drain bus. It runs on a fast system clock and samples the bus line through a two-flop synchroniser. A clock divider turns the system clock into a microsecond time base, and all bus timing is measured against it. When the master holds the line low long enough, the block treats it as a bus reset. It then answers with a presence pulse of its own and tells the layer above that the bus was reset.

Each falling edge from the master starts a time slot. In a write slot the block samples the line at a fixed point after the edge and decodes one bit. It gathers eight bits into a byte, first bit into the least significant position, and hands the byte upward with a one-cycle valid strobe. In a read slot the block sends the next bit of a byte loaded by the layer above, least significant bit first. To send a zero it pulls the line low for a short hold time. To send a one it leaves the line alone. The mode input decides whether idle slots are decoded as writes or answered as reads. A program-pulse strobe input stands in for a high-voltage pulse: each of its rising edges becomes a single-cycle event to the layer above.

Top module: `sw_slave_link`

## Requirements
- R1: After reset, bus_pd_o, tx_busy_o, rx_valid_o, bus_reset_o and prog_evt_o are all 0.
- R2: A bus low lasting at least T_RST_US microseconds gives one single-cycle bus_reset_o pulse. A low of 400 µs gives none.
- R3: Once the line rises after a bus reset, bus_pd_o stays 0 for T_PD_WAIT_US (30 µs). It is then 1 for T_PD_LEN_US (120 µs), and then returns to 0. With the defaults, bus_pd_o is 0 at 20 µs after the rise, 1 at 40 µs and at 140 µs, and 0 at 170 µs.
- R4: When not transmitting and mode_tx_i is 0, each slot is decoded as a write bit: low at the sample point means 0, high means 1. After eight slots, rx_data_o holds the byte, first slot in bit 0, and rx_valid_o pulses for one cycle.
- R5: While tx_busy_o is 1, each slot is a read slot carrying bit 0 of the loaded byte first. A 0 bit asserts bus_pd_o from shortly after the master's falling edge until T_HOLD_US (15 µs). It is 1 at 8 µs and 0 at 20 µs. A 1 bit never asserts bus_pd_o.
- R6: With mode_tx_i at 1 and no byte loaded, read slots return 1, bus_pd_o stays 0, and no byte is received.
- R7: tx_load_i while tx_busy_o is 0 loads tx_data_i and sets tx_busy_o. tx_busy_o clears after the eighth read slot. A load while tx_busy_o is 1 is ignored.
- R8: A bus reset drops any partly received byte and any byte being sent. A tx_load_i in the same cycle as bus_reset_o is ignored.
- R9: Each rising edge of prog_pulse_i gives exactly one prog_evt_o pulse, one cycle later, however long the input stays high.
- R10: The write sample point is T_SAMPLE_US (15 µs) after the falling edge. A master low of 12 µs decodes as 1, and a master low of 18 µs decodes as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Sampled level of the bus line |
| bus_pd_o | output | 1 | Pull-down enable for the bus line, active high |
| mode_tx_i | input | 1 | 1: idle slots are read slots answered with 1; 0: idle slots are write slots |
| tx_data_i | input | 8 | Byte to send |
| tx_load_i | input | 1 | Load strobe for tx_data_i |
| tx_busy_o | output | 1 | A loaded byte is still being sent |
| rx_data_o | output | 8 | Last byte received |
| rx_valid_o | output | 1 | Single-cycle strobe for rx_data_o |
| bus_reset_o | output | 1 | Single-cycle strobe when a bus reset is detected |
| prog_pulse_i | input | 1 | Program-pulse strobe |
| prog_evt_o | output | 1 | Single-cycle event on each rising edge of prog_pulse_i |

## Verification
Reset detection and a byte load from the layer above can happen in the same clock cycle. The abort must win, otherwise a stale byte would go out after the presence pulse. The bench provokes this during a long reset low. It watches for bus_reset_o between clock edges and drives tx_load_i with a zero byte for exactly that cycle. It then expects tx_busy_o to be 0, and the first byte read after the presence pulse to be all ones. Random bytes are written and read in both directions. Directed cases cover the sample point and the presence window.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_WAIT_HI,
    ST_RST,
    ST_PRES_WAIT,
    ST_PRES_DRV,
    ST_PRES_REL
  } slot_st_e;
endpackage

// File: rtl/sw_edge_sync.sv
module sw_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o    = s2_q;
  assign fall_o = s3_q & ~s2_q;
  assign rise_o = ~s3_q & s2_q;
endmodule

// File: rtl/sw_us_timer.sv
module sw_us_timer #(
  parameter int CLK_PER_US = 50,
  parameter int US_W       = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  output logic [US_W-1:0] us_o
);
  localparam int DIV_W = $clog2(CLK_PER_US) + 1;
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick = (div_q == DIV_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      us_o  <= '0;
    end else if (clr_i) begin
      div_q <= '0;
      us_o  <= '0;
    end else if (tick) begin
      div_q <= '0;
      if (us_o != '1) us_o <= us_o + 1'b1;  // saturate
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sw_slot_ctrl.sv
module sw_slot_ctrl
  import sw_pkg::*;
#(
  parameter int US_W         = 10,
  parameter int T_RST_US     = 480,
  parameter int T_PD_WAIT_US = 30,
  parameter int T_PD_LEN_US  = 120,
  parameter int T_SAMPLE_US  = 15,
  parameter int T_HOLD_US    = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_s_i,
  input  logic            fall_i,
  input  logic            rise_i,
  input  logic [US_W-1:0] us_i,
  input  logic            rd_req_i,
  input  logic            rd_act_i,
  input  logic            rd_bit_i,
  output logic            clr_o,
  output logic            pd_o,
  output logic            bit_done_o,
  output logic            bit_o,
  output logic            slot_rd_o,
  output logic            slot_act_o,
  output logic            bus_rst_o
);
  localparam logic [US_W-1:0] T_RST    = US_W'(T_RST_US);
  localparam logic [US_W-1:0] T_PDWAIT = US_W'(T_PD_WAIT_US);
  localparam logic [US_W-1:0] T_PDLEN  = US_W'(T_PD_LEN_US);
  localparam logic [US_W-1:0] T_SAMPLE = US_W'(T_SAMPLE_US);
  localparam logic [US_W-1:0] T_HOLD   = US_W'(T_HOLD_US);

  slot_st_e st_q, st_d;
  logic     rd_q, act_q, rbit_q;

  always_comb begin
    st_d       = st_q;
    clr_o      = 1'b0;
    bit_done_o = 1'b0;
    bus_rst_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (fall_i) begin
        st_d  = ST_SLOT;
        clr_o = 1'b1;
      end
      ST_SLOT: if (us_i >= (rd_q ? T_HOLD : T_SAMPLE)) begin
        bit_done_o = 1'b1;
        st_d       = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        if (bus_s_i) st_d = ST_IDLE;
        else if (us_i >= T_RST) begin
          bus_rst_o = 1'b1;
          st_d      = ST_RST;
        end
      end
      ST_RST: if (rise_i) begin
        st_d  = ST_PRES_WAIT;
        clr_o = 1'b1;
      end
      ST_PRES_WAIT: if (us_i >= T_PDWAIT) begin
        st_d  = ST_PRES_DRV;
        clr_o = 1'b1;
      end
      ST_PRES_DRV: if (us_i >= T_PDLEN) st_d = ST_PRES_REL;
      ST_PRES_REL: if (bus_s_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rd_q   <= 1'b0;
      act_q  <= 1'b0;
      rbit_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && fall_i) begin  // slot type fixed at its edge
        rd_q   <= rd_req_i;
        act_q  <= rd_act_i;
        rbit_q <= rd_bit_i;
      end
    end
  end

  assign pd_o       = (st_q == ST_PRES_DRV) | (st_q == ST_SLOT & rd_q & ~rbit_q);
  assign bit_o      = bus_s_i;
  assign slot_rd_o  = rd_q;
  assign slot_act_o = act_q;
endmodule

// File: rtl/sw_byte_shift.sv
module sw_byte_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              mode_tx_i,
  input  logic              bit_done_i,
  input  logic              bit_i,
  input  logic              slot_rd_i,
  input  logic              slot_act_i,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              rd_req_o,
  output logic              rd_act_o,
  output logic              rd_bit_o,
  output logic              tx_busy_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] rx_sr_q, tx_sr_q, rx_next;
  logic [CNT_W-1:0]  rx_cnt_q, tx_cnt_q;

  assign rx_next = {bit_i, rx_sr_q[BYTE_W-1:1]};  // first bit lands in bit 0

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      rx_cnt_q   <= '0;
      tx_cnt_q   <= '0;
      tx_busy_o  <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (abort_i) begin
        rx_cnt_q  <= '0;
        tx_cnt_q  <= '0;
        tx_busy_o <= 1'b0;
      end else begin
        if (bit_done_i && !slot_rd_i) begin
          rx_sr_q <= rx_next;
          if (rx_cnt_q == LAST) begin
            rx_cnt_q   <= '0;
            rx_data_o  <= rx_next;
            rx_valid_o <= 1'b1;
          end else begin
            rx_cnt_q <= rx_cnt_q + 1'b1;
          end
        end
        if (bit_done_i && slot_rd_i && slot_act_i && tx_busy_o) begin
          tx_sr_q <= tx_sr_q >> 1;
          if (tx_cnt_q == LAST) begin
            tx_cnt_q  <= '0;
            tx_busy_o <= 1'b0;
          end else begin
            tx_cnt_q <= tx_cnt_q + 1'b1;
          end
        end else if (tx_load_i && !tx_busy_o) begin
          tx_sr_q   <= tx_data_i;
          tx_cnt_q  <= '0;
          tx_busy_o <= 1'b1;
        end
      end
    end
  end

  assign rd_req_o = tx_busy_o | mode_tx_i;
  assign rd_act_o = tx_busy_o;
  assign rd_bit_o = tx_busy_o ? tx_sr_q[0] : 1'b1;
endmodule

// File: rtl/sw_slave_link.sv
module sw_slave_link #(
  parameter int CLK_PER_US   = 50,
  parameter int BYTE_W       = 8,
  parameter int T_RST_US     = 480,
  parameter int T_PD_WAIT_US = 30,
  parameter int T_PD_LEN_US  = 120,
  parameter int T_SAMPLE_US  = 15,
  parameter int T_HOLD_US    = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_i,
  output logic              bus_pd_o,
  input  logic              mode_tx_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic              tx_busy_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              bus_reset_o,
  input  logic              prog_pulse_i,
  output logic              prog_evt_o
);
  localparam int US_W = $clog2(T_RST_US + T_PD_LEN_US + 1) + 1;

  logic            bus_s, fall, rise, clr;
  logic [US_W-1:0] us;
  logic            rd_req, rd_act, rd_bit;
  logic            bit_done, bit_val, slot_rd, slot_act;
  logic            prog_q;

  sw_edge_sync u_sync (
    .clk_i, .rst_ni, .d_i(bus_i), .q_o(bus_s), .fall_o(fall), .rise_o(rise)
  );

  sw_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
    .clk_i, .rst_ni, .clr_i(clr), .us_o(us)
  );

  sw_slot_ctrl #(
    .US_W(US_W), .T_RST_US(T_RST_US), .T_PD_WAIT_US(T_PD_WAIT_US),
    .T_PD_LEN_US(T_PD_LEN_US), .T_SAMPLE_US(T_SAMPLE_US), .T_HOLD_US(T_HOLD_US)
  ) u_ctrl (
    .clk_i, .rst_ni, .bus_s_i(bus_s), .fall_i(fall), .rise_i(rise), .us_i(us),
    .rd_req_i(rd_req), .rd_act_i(rd_act), .rd_bit_i(rd_bit),
    .clr_o(clr), .pd_o(bus_pd_o), .bit_done_o(bit_done), .bit_o(bit_val),
    .slot_rd_o(slot_rd), .slot_act_o(slot_act), .bus_rst_o(bus_reset_o)
  );

  sw_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .abort_i(bus_reset_o), .mode_tx_i,
    .bit_done_i(bit_done), .bit_i(bit_val), .slot_rd_i(slot_rd), .slot_act_i(slot_act),
    .tx_load_i, .tx_data_i, .rd_req_o(rd_req), .rd_act_o(rd_act), .rd_bit_o(rd_bit),
    .tx_busy_o, .rx_data_o, .rx_valid_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q     <= 1'b0;
      prog_evt_o <= 1'b0;
    end else begin
      prog_q     <= prog_pulse_i;
      prog_evt_o <= prog_pulse_i & ~prog_q;
    end
  end
endmodule

// File: rtl/sw_slave_link_chk.sv
module sw_slave_link_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_reset_o,
  input logic tx_busy_o,
  input logic tx_load_i,
  input logic rx_valid_o,
  input logic prog_pulse_i,
  input logic prog_evt_o
);
  a_r2_reset_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |=> !bus_reset_o);
  a_r8_reset_drops_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |=> !tx_busy_o);
  a_r7_busy_from_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |-> $past(tx_load_i));
  a_r4_rx_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r9_prog_evt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_evt_o |=> !prog_evt_o);
  a_r9_prog_evt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_evt_o |-> $past(prog_pulse_i));
endmodule

bind sw_slave_link sw_slave_link_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_o(bus_reset_o), .tx_busy_o(tx_busy_o),
  .tx_load_i(tx_load_i), .rx_valid_o(rx_valid_o), .prog_pulse_i(prog_pulse_i),
  .prog_evt_o(prog_evt_o)
);

// File: tb/sw_slave_link_bench.sv
module sw_slave_link_bench;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_low = 1'b0;
  logic       line;
  logic       pd, mode_tx = 1'b0, tx_load = 1'b0, busy, rx_valid, bus_rst;
  logic [7:0] tx_data = '0, rx_data;
  logic       prog = 1'b0, prog_evt;

  int checks = 0, errors = 0;
  int rx_seen = 0, rst_seen = 0, prog_seen = 0, pd_cyc = 0;
  logic [7:0] rx_last = '0;

  always #2 clk = ~clk;
  assign line = ~(m_low | pd);

  sw_slave_link #(.CLK_PER_US(CPU)) u_sw_slave_link (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(line), .bus_pd_o(pd), .mode_tx_i(mode_tx),
    .tx_data_i(tx_data), .tx_load_i(tx_load), .tx_busy_o(busy), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .bus_reset_o(bus_rst), .prog_pulse_i(prog), .prog_evt_o(prog_evt)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_seen++; rx_last = rx_data; end
    if (bus_rst) rst_seen++;
    if (prog_evt) prog_seen++;
    if (pd) pd_cyc++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_us(input int n);
    repeat (n * CPU) @(negedge clk);
  endtask

  task automatic bus_reset();
    m_low = 1'b1; wait_us(500);
    m_low = 1'b0; wait_us(200);
  endtask

  task automatic write_len(input int low_us);
    m_low = 1'b1; wait_us(low_us);
    m_low = 1'b0; wait_us(70 - low_us);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_len(v[i] ? 6 : 60);
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      m_low = 1'b1; wait_us(2);
      m_low = 1'b0; wait_us(8);
      v[i] = line;
      wait_us(60);
    end
  endtask

  task automatic load(input logic [7:0] v);
    tx_data = v; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  initial begin
    logic [7:0] v, got;
    int n, p;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pd", pd, 0);
    check("R1 busy", busy, 0);
    check("R1 valid/rst/evt", {rx_valid, bus_rst, prog_evt}, 0);

    // R2 short low is not a reset; no presence follows
    p = pd_cyc;
    m_low = 1'b1; wait_us(400); m_low = 1'b0; wait_us(200);
    check("R2 400us low", rst_seen, 0);
    check("R2 no presence", pd_cyc, p);

    // R2/R3 full reset and presence window
    m_low = 1'b1; wait_us(500);
    check("R2 reset pulse", rst_seen, 1);
    m_low = 1'b0;
    wait_us(20);  check("R3 pd at 20us", pd, 0);
    wait_us(20);  check("R3 pd at 40us", pd, 1);
    wait_us(100); check("R3 pd at 140us", pd, 1);
    wait_us(30);  check("R3 pd at 170us", pd, 0);
    wait_us(50);

    // R4 directed then random receive
    foreach (v[i]) v[i] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      case (k)
        0: v = 8'h00; 1: v = 8'hFF; 2: v = 8'h01; 3: v = 8'h80;
        default: v = 8'($urandom);
      endcase
      n = rx_seen;
      write_byte(v);
      check("R4 rx count", rx_seen, n + 1);
      check("R4 rx data", rx_last, v);
    end

    // R10 sample point: 12us low reads 1, 18us low reads 0
    n = rx_seen;
    for (int i = 0; i < 8; i++) write_len(i[0] ? 18 : 12);
    check("R10 sample point", rx_last, 8'h55);
    check("R10 rx count", rx_seen, n + 1);

    // R5/R7 transmit random bytes
    mode_tx = 1'b1;
    for (int k = 0; k < 4; k++) begin
      v = 8'($urandom);
      load(v);
      check("R7 busy after load", busy, 1);
      read_byte(got);
      check("R5 read byte", got, v);
      check("R7 busy cleared", busy, 0);
    end

    // R5 pull-down timing of a 0 bit
    load(8'h00);
    m_low = 1'b1; wait_us(2); m_low = 1'b0;
    wait_us(6);  check("R5 pd at 8us", pd, 1);
    wait_us(12); check("R5 pd at 20us", pd, 0);
    wait_us(50);
    for (int i = 1; i < 8; i++) begin
      m_low = 1'b1; wait_us(2); m_low = 1'b0; wait_us(68);
    end
    check("R5 busy after 8 slots", busy, 0);

    // R6 nothing loaded: ones, no pull-down, no receive
    p = pd_cyc; n = rx_seen;
    read_byte(got);
    check("R6 idle read", got, 8'hFF);
    check("R6 no pd", pd_cyc, p);
    check("R6 no rx", rx_seen, n);

    // R7 load while busy ignored
    load(8'h3C);
    load(8'hC3);
    read_byte(got); check("R7 first byte", got, 8'h3C);
    read_byte(got); check("R7 second load ignored", got, 8'hFF);

    // R8 partial receive dropped by reset
    mode_tx = 1'b0;
    write_len(6); write_len(60); write_len(6);
    bus_reset();
    n = rx_seen;
    write_byte(8'hA5);
    check("R8 rx after abort", rx_last, 8'hA5);
    check("R8 rx count", rx_seen, n + 1);

    // R8 partial transmit dropped by reset
    mode_tx = 1'b1;
    load(8'h00);
    for (int i = 0; i < 3; i++) begin
      m_low = 1'b1; wait_us(2); m_low = 1'b0; wait_us(68);
    end
    bus_reset();
    check("R8 busy after abort", busy, 0);
    read_byte(got); check("R8 tx after abort", got, 8'hFF);

    // R8 load in the reset detection cycle loses
    m_low = 1'b1;
    do @(negedge clk); while (!bus_rst);
    tx_data = 8'h00; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    check("R8 same-cycle load", busy, 0);
    wait_us(20); m_low = 1'b0; wait_us(200);
    read_byte(got); check("R8 same-cycle tx", got, 8'hFF);

    // R9 program pulse
    n = prog_seen;
    prog = 1'b1; repeat (6) @(negedge clk); prog = 1'b0;
    repeat (3) @(negedge clk);
    prog = 1'b1; @(negedge clk); prog = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 prog events", prog_seen, n + 2);

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule